// File: doc/BRIEF.md
# Serial Converter Read Controller

This block runs one complete acquisition on a 12-bit successive-approximation converter that has a three-wire serial link and, in its two-channel form, a serial configuration input. The block sits on the host side. A one-cycle `start` pulse begins the run. The controller pulls the convert strobe low for one cycle and then raises it, because a rising strobe edge is what starts a conversion. It holds the strobe high for a fixed number of system clock cycles while the converter works. It then drops the strobe, which enables the converter's data output. Next it produces 12 shift clocks and captures one result bit on each rising edge, most significant bit first.

During the first two of those clocks the controller drives a 2-bit channel word onto the converter's configuration input, in full duplex with the readout. The single-ended/differential select goes first (`cfg_in[1]`) and the odd/sign select follows (`cfg_in[0]`). This word chooses the inputs of the *next* conversion, so the value read back always belongs to the channel word sent one run earlier. After the last bit the strobe goes high again, so the converter can convert or sleep. The controller then pulses `done` with the finished word on `result`.

The state sequence is IDLE → PRIME (strobe low, one cycle) → CONVERT (strobe high, conversion wait) → SETUP (strobe low, shift clock low) → CLK_HI ⇄ CLK_LO (one pair per bit) → HOLD (strobe held low after the last rising edge) → FINISH (strobe high, `done`) → IDLE. The transitions are:
- IDLE→PRIME on `start`.
- PRIME→CONVERT, CONVERT→SETUP, SETUP→CLK_HI, CLK_LO→CLK_HI and HOLD→FINISH when the phase timer expires.
- CLK_HI→CLK_LO on timer expiry while bits remain.
- CLK_HI→HOLD on timer expiry after the 12th bit.
- FINISH→IDLE unconditionally.

Every phase length is a parameter counted in system clock cycles.

Top module: `adc_read_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, `cnv`, `sck`, `sdi`, `busy` and `done` are 0 and `result` is 0.
- R2: A `start` accepted in idle drives `cnv` low for exactly one cycle and then high for exactly CONV_CYC cycles, and only then drops it.
- R3: After `cnv` falls, `sck` stays low for max(SETUP_CYC, HALF_CYC) cycles before its first rising edge.
- R4: Each run produces exactly RES_BITS rising edges on `sck`. Every high phase lasts HALF_CYC cycles and every low phase between rising edges lasts HALF_CYC cycles. `sck` is never high while `cnv` is high.
- R5: `sdo_in` is sampled on each rising `sck` edge. `result` holds the sampled bits with the first one in bit RES_BITS-1 (MSB first).
- R6: `sdi` carries `cfg_in[1]` at the first rising `sck` edge and `cfg_in[0]` at the second, using the `cfg_in` value present when `start` was accepted. `sdi` is 0 at every later rising edge and whenever `busy` is low.
- R7: After the last rising `sck` edge, `cnv` stays low for HALF_CYC+HOLD_CYC cycles. It then rises in the same cycle as a one-cycle `done` pulse, and it stays high while idle.
- R8: `busy` is high from the cycle after `start` is accepted until `done`. `busy` and `done` are never high together.
- R9: `start` has no effect while a run is in progress. A pulse during a run changes neither the latency, the channel word sent nor the result, and no second run follows.
- R10: `done` rises 1+CONV_CYC+max(SETUP_CYC,HALF_CYC)+(2·RES_BITS−1)·HALF_CYC+HOLD_CYC cycles after the clock edge that accepts `start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin one acquisition (accepted only when idle) |
| cfg_in | input | 2 | Channel word for the next conversion: [1] single/differential, [0] odd/sign |
| sdo_in | input | 1 | Serial result bit from the converter |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse: `result` is valid |
| result | output | 12 | Last received conversion word |
| cnv | output | 1 | Convert strobe to the converter |
| sck | output | 1 | Shift clock to the converter |
| sdi | output | 1 | Configuration bit to the converter |

## Verification
The bench builds the controller with CONV_CYC=20, HALF_CYC=2, SETUP_CYC=3 and HOLD_CYC=1, which gives a 71-cycle run. The short wait keeps many runs within the cycle budget. Because the setup length exceeds the half period, the bench can tell whether the pre-clock low time follows the larger of the two settings. A behavioural converter model latches a word per channel code on each strobe rise, shifts it out on falling clocks, and captures the two configuration bits on rising clocks. This lets the bench check the one-run lag between the channel word sent and the word returned, and it makes all-zero, all-one and alternating patterns visible bit by bit.

// File: rtl/adcrd_pkg.sv
package adcrd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRIME,
        ST_CONVERT,
        ST_SETUP,
        ST_CLK_HI,
        ST_CLK_LO,
        ST_HOLD,
        ST_FINISH
    } adcrd_state_e;

endpackage

// File: rtl/adcrd_timer.sv
module adcrd_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/adcrd_shreg.sv
module adcrd_shreg #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         in_bit,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (shift) begin
            if (W > 1) begin
                q <= {q[W-2:0], in_bit};
            end else begin
                q <= in_bit;
            end
        end
    end

endmodule

// File: rtl/adc_read_ctrl.sv
module adc_read_ctrl
    import adcrd_pkg::*;
#(
    parameter int RES_BITS  = 12,
    parameter int CFG_BITS  = 2,
    parameter int CONV_CYC  = 320,
    parameter int HALF_CYC  = 3,
    parameter int SETUP_CYC = 3,
    parameter int HOLD_CYC  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [CFG_BITS-1:0] cfg_in,
    input  logic                sdo_in,
    output logic                busy,
    output logic                done,
    output logic [RES_BITS-1:0] result,
    output logic                cnv,
    output logic                sck,
    output logic                sdi
);

    // low time before first rising clock must meet both the setup and half-period rules
    localparam int SETUP_LEN = (SETUP_CYC > HALF_CYC) ? SETUP_CYC : HALF_CYC;
    localparam int MAX_A     = (CONV_CYC > SETUP_LEN) ? CONV_CYC : SETUP_LEN;
    localparam int MAX_B     = (HALF_CYC > HOLD_CYC) ? HALF_CYC : HOLD_CYC;
    localparam int MAX_LEN   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int TMR_W     = $clog2(MAX_LEN + 1);
    localparam int CNT_W     = $clog2(RES_BITS + 1);

    adcrd_state_e state_q, nxt;

    logic             tmr_exp;
    logic [TMR_W-1:0] tmr_val;
    logic [CNT_W-1:0] bits_q;
    logic             run_begin;
    logic             enter_hi;
    logic             leave_hi;
    logic [RES_BITS-1:0] res_sh;
    logic [CFG_BITS-1:0] cfg_sh;
    logic             cnv_q, sck_q, busy_q, done_q;
    logic [RES_BITS-1:0] result_q;

    function automatic logic [TMR_W-1:0] dur_of(adcrd_state_e s);
        unique case (s)
            ST_CONVERT: return TMR_W'(CONV_CYC - 1);
            ST_SETUP:   return TMR_W'(SETUP_LEN - 1);
            ST_CLK_HI:  return TMR_W'(HALF_CYC - 1);
            ST_CLK_LO:  return TMR_W'(HALF_CYC - 1);
            ST_HOLD:    return TMR_W'(HOLD_CYC - 1);
            default:    return '0;
        endcase
    endfunction

    // next-state decision
    always_comb begin
        nxt = state_q;
        unique case (state_q)
            ST_IDLE:    if (start)   nxt = ST_PRIME;
            ST_PRIME:   if (tmr_exp) nxt = ST_CONVERT;
            ST_CONVERT: if (tmr_exp) nxt = ST_SETUP;
            ST_SETUP:   if (tmr_exp) nxt = ST_CLK_HI;
            ST_CLK_HI:  if (tmr_exp) nxt = (bits_q == CNT_W'(RES_BITS)) ? ST_HOLD : ST_CLK_LO;
            ST_CLK_LO:  if (tmr_exp) nxt = ST_CLK_HI;
            ST_HOLD:    if (tmr_exp) nxt = ST_FINISH;
            ST_FINISH:               nxt = ST_IDLE;
            default:                 nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= nxt;
        end
    end

    assign run_begin = (state_q == ST_IDLE) && (nxt == ST_PRIME);
    assign enter_hi  = (state_q != ST_CLK_HI) && (nxt == ST_CLK_HI);
    assign leave_hi  = (state_q == ST_CLK_HI) && (nxt != ST_CLK_HI);
    assign tmr_val   = dur_of(nxt);

    adcrd_timer #(.W(TMR_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (nxt != state_q),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    // received bits, MSB first
    adcrd_shreg #(.W(RES_BITS)) i_res_sh (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (run_begin),
        .load_val ('0),
        .shift    (enter_hi),
        .in_bit   (sdo_in),
        .q        (res_sh)
    );

    // outgoing channel word, MSB first, refilled with zeros
    adcrd_shreg #(.W(CFG_BITS)) i_cfg_sh (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (run_begin),
        .load_val (cfg_in),
        .shift    (leave_hi),
        .in_bit   (1'b0),
        .q        (cfg_sh)
    );

    // bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else if (run_begin) begin
            bits_q <= '0;
        end else if (enter_hi) begin
            bits_q <= bits_q + 1'b1;
        end
    end

    // registered pin and handshake outputs, decoded from the next state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnv_q    <= 1'b0;
            sck_q    <= 1'b0;
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
            result_q <= '0;
        end else begin
            cnv_q  <= (nxt == ST_CONVERT) || (nxt == ST_FINISH) || ((nxt == ST_IDLE) && cnv_q);
            sck_q  <= (nxt == ST_CLK_HI);
            busy_q <= (nxt != ST_IDLE) && (nxt != ST_FINISH);
            done_q <= (nxt == ST_FINISH);
            if (nxt == ST_FINISH) begin
                result_q <= res_sh;
            end
        end
    end

    assign cnv    = cnv_q;
    assign sck    = sck_q;
    assign sdi    = cfg_sh[CFG_BITS-1];
    assign busy   = busy_q;
    assign done   = done_q;
    assign result = result_q;

endmodule

// File: rtl/adcrd_checker.sv
module adcrd_checker (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic cnv,
    input logic sck,
    input logic sdi
);

    assert_sck_needs_low_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sck |-> !cnv);

    assert_strobe_low_before_clock_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |-> $past(!cnv));

    assert_prime_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !cnv);

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_strobe_high_at_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> cnv);

    assert_busy_done_apart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    assert_busy_until_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> (busy || done));

    assert_no_restart_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    assert_cfg_quiet_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sdi);

endmodule

bind adc_read_ctrl adcrd_checker i_adcrd_checker (
    .clk   (clk),
    .rst_n (rst_n),
    .busy  (busy),
    .done  (done),
    .cnv   (cnv),
    .sck   (sck),
    .sdi   (sdi)
);

// File: tb/test_adc_read_ctrl.sv
module test_adc_read_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int RES  = 12;
    localparam int CFGB = 2;
    localparam int CONV = 20;
    localparam int HALF = 2;
    localparam int SETP = 3;
    localparam int HOLD = 1;
    localparam int SLEN = (SETP > HALF) ? SETP : HALF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] cfg_in = 2'b00;
    logic sdo_in;
    logic busy, done, cnv, sck, sdi;
    logic [RES-1:0] result;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_read_ctrl #(
        .RES_BITS(RES), .CFG_BITS(CFGB), .CONV_CYC(CONV),
        .HALF_CYC(HALF), .SETUP_CYC(SETP), .HOLD_CYC(HOLD)
    ) i_adc_read_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_in(cfg_in), .sdo_in(sdo_in),
        .busy(busy), .done(done), .result(result), .cnv(cnv), .sck(sck), .sdi(sdi)
    );

    // ---------------- behavioural converter model ----------------
    logic [RES-1:0] dev_word [4];
    logic [RES-1:0] conv_word = '0;
    logic [RES-1:0] out_sh = '0;
    int  epoch = 0;
    int  seen_epoch = 0;
    logic [1:0] mux_sel = 2'b00;
    logic [1:0] cap = 2'b00;
    int  ccnt = 0;

    initial sdo_in = 1'b0;

    always @(posedge cnv) begin
        conv_word = dev_word[mux_sel];
        epoch = epoch + 1;
    end

    always @(negedge cnv or negedge sck) begin
        if (epoch != seen_epoch) begin
            seen_epoch = epoch;
            out_sh = conv_word;
        end else begin
            out_sh = out_sh << 1;
        end
        sdo_in = out_sh[RES-1];
    end

    always @(negedge cnv or posedge sck) begin
        if (sck) begin
            if (ccnt < 2) begin
                cap = {cap[0], sdi};
                ccnt = ccnt + 1;
                if (ccnt == 2) mux_sel = cap;
            end
        end else begin
            ccnt = 0;
        end
    end

    // ---------------- pin monitor ----------------
    int cnv_hi, cnv_lo, hi_len, conv_len, setup_len, rises;
    int sck_hi, sck_lo, wid_err, ovl_err, sdi_err, post;
    logic cnv_p, sck_p, busy_p;

    always @(negedge clk) begin
        if (!rst_n) begin
            cnv_hi = 0; cnv_lo = 0; hi_len = 0; conv_len = 0; setup_len = 0; rises = 0;
            sck_hi = 0; sck_lo = 0; wid_err = 0; ovl_err = 0; sdi_err = 0; post = 0;
            cnv_p = 0; sck_p = 0; busy_p = 0;
        end else begin
            if (busy && !busy_p) begin
                rises = 0; wid_err = 0; ovl_err = 0; sdi_err = 0; post = 0;
                setup_len = -1; conv_len = -1;
            end
            if (cnv) begin
                if (!cnv_p) cnv_hi = 1; else cnv_hi = cnv_hi + 1;
            end else begin
                if (cnv_p) begin hi_len = cnv_hi; cnv_lo = 1; end
                else cnv_lo = cnv_lo + 1;
            end
            if (sck && cnv) ovl_err = ovl_err + 1;
            if (sck && !sck_p) begin
                if (rises == 0) begin
                    setup_len = cnv_lo - 1;
                    conv_len = hi_len;
                end else if (sck_lo != HALF) begin
                    wid_err = wid_err + 1;
                end
                if (rises >= CFGB && sdi) sdi_err = sdi_err + 1;
                rises = rises + 1;
                sck_hi = 1;
                post = 0;
            end else begin
                if (sck) sck_hi = sck_hi + 1;
                else if (sck_p) begin
                    if (sck_hi != HALF) wid_err = wid_err + 1;
                    sck_lo = 1;
                end else sck_lo = sck_lo + 1;
                if (!cnv && rises > 0) post = post + 1;
            end
            cnv_p = cnv; sck_p = sck; busy_p = busy;
        end
    end

    // ---------------- bench helpers ----------------
    function automatic int exp_latency();
        return 1 + CONV + SLEN + (2 * RES - 1) * HALF + HOLD;
    endfunction

    function automatic logic [RES-1:0] exp_word(input logic [1:0] prev_cfg);
        return dev_word[prev_cfg];
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    logic [1:0] prev_cfg = 2'b00;

    task automatic run(input logic [1:0] c, input bit poke);
        int cyc;
        logic [RES-1:0] ew;
        ew = exp_word(prev_cfg);
        @(negedge clk);
        cfg_in = c;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy === 1'b1, "R8", "busy after start", int'(busy), 1);
        cyc = 0;
        while (done !== 1'b1 && cyc < 2000) begin
            @(negedge clk);
            cyc++;
            if (poke && cyc == 5) begin start = 1'b1; cfg_in = ~c; end
            else start = 1'b0;
            if (done !== 1'b1) cfg_in = poke ? ~c : c;
        end
        start = 1'b0;
        check(cyc < 2000, "R10", "watchdog on done", cyc, exp_latency());
        check(cyc == exp_latency(), poke ? "R9" : "R10", "start-to-done cycles", cyc, exp_latency());
        check(result === ew, "R5", "received word", int'(result), int'(ew));
        check(cap === c, "R6", "channel word seen by converter", int'(cap), int'(c));
        check(sdi_err == 0, "R6", "sdi nonzero after channel bits", sdi_err, 0);
        check(rises == RES, "R4", "rising clocks per run", rises, RES);
        check(wid_err == 0 && ovl_err == 0, "R4", "clock phase errors", wid_err + ovl_err, 0);
        check(conv_len == CONV, "R2", "strobe high before readout", conv_len, CONV);
        check(setup_len == SLEN, "R3", "strobe low before first clock", setup_len, SLEN);
        check(post == HALF + HOLD - 1, "R7", "strobe low after last rise", post + 1, HALF + HOLD);
        check(cnv === 1'b1 && busy === 1'b0, "R7", "strobe high and not busy at done",
              int'({cnv, busy}), 2);
        @(negedge clk);
        check(done === 1'b0 && cnv === 1'b1, "R7", "done single cycle, strobe stays high",
              int'({done, cnv}), 1);
        check(busy === 1'b0, "R9", "no further run after done", int'(busy), 0);
        check(sdi === 1'b0, "R6", "sdi quiet when idle", int'(sdi), 0);
        prev_cfg = c;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed_val;
        seed_val = $urandom(32'h5EED_0A1C);
        for (int i = 0; i < 4; i++) dev_word[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset values
        check({cnv, sck, sdi, busy, done} === 5'b0, "R1", "pins during reset",
              int'({cnv, sck, sdi, busy, done}), 0);
        check(result === '0, "R1", "result during reset", int'(result), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check({cnv, sck, sdi, busy, done} === 5'b0, "R1", "pins after reset",
              int'({cnv, sck, sdi, busy, done}), 0);

        // directed patterns
        for (int i = 0; i < 4; i++) dev_word[i] = 12'h000;
        run(2'b10, 1'b0);
        for (int i = 0; i < 4; i++) dev_word[i] = 12'hFFF;
        run(2'b01, 1'b0);
        for (int i = 0; i < 4; i++) dev_word[i] = 12'hAAA ^ 12'(i);
        run(2'b11, 1'b0);
        for (int i = 0; i < 4; i++) dev_word[i] = 12'h555 + 12'(i << 8);
        run(2'b00, 1'b1);
        run(2'b11, 1'b1);

        // random runs
        for (int n = 0; n < 16; n++) begin
            for (int i = 0; i < 4; i++) dev_word[i] = 12'($urandom);
            run(2'($urandom), (n % 5) == 0);
            repeat ($urandom_range(0, 3)) @(negedge clk);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule